// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block sits beside the transmit and receive FIFOs of a serial peripheral and turns their fill levels and push/pop strobes into status flags and one interrupt line. The FIFO storage and the shift engine live elsewhere. This block receives only the two fill levels, the push and pop strobes, and a busy indication from the engine.

Software programs a threshold for each FIFO. The transmit threshold event is a level: it is high while the transmit FIFO holds no more entries than its threshold. The receive threshold event is also a level: it is high while the receive FIFO holds more entries than its threshold. Three error events are sticky: a push into a full transmit FIFO, a push into a full receive FIFO, and a pop from an empty receive FIFO. Each stays set until software clears it through a write-only clear register. A mask selects which raw events reach the interrupt line.

A threshold register accepts only values below the FIFO depth. Software can therefore find the depth by writing increasing values until one does not read back. The usual setting for both thresholds is half the depth minus one. All register accesses use a plain single-cycle write strobe and a combinational read port. There is no streaming data path, so no valid/ready handshake is used.

Top module: `fic_top`

## Requirements
- R1: After reset, both thresholds read 0, the mask reads 0, every sticky event is clear and `irq` is low.
- R2: A write to a threshold register (address 0 for transmit, 1 for receive) with a value below DEPTH is stored and reads back. A write with a value of DEPTH or more is ignored, and the previous value still reads back.
- R3: The status register (address 4) reads busy at bit 0, transmit full at bit 1, transmit empty at bit 2, receive empty at bit 3 and receive full at bit 4. A FIFO counts as full when its level equals DEPTH and as empty when its level is 0.
- R4: Raw event bit 0 is 1 exactly while the transmit level is at or below the transmit threshold.
- R5: Raw event bit 4 is 1 exactly while the receive level is above the receive threshold.
- R6: The raw event register is at address 6. A transmit push while the transmit level equals DEPTH sets raw bit 1. A receive pop while the receive level is 0 sets raw bit 2. A receive push while the receive level equals DEPTH sets raw bit 3. Each bit is visible from the cycle after the strobe and holds until it is cleared. A push or pop that is not an error sets nothing.
- R7: A write to address 8 clears sticky events. Write-data bit 0 clears raw bits 1, 2 and 3. Bit 1 clears raw bit 2, bit 2 clears raw bit 3 and bit 3 clears raw bit 1. Sticky bits that are not selected stay unchanged.
- R8: When an error event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R9: The mask (address 5) uses the raw layout. The masked view (address 7) is raw AND mask, and `irq` is high exactly when any masked bit is 1.
- R10: Addresses 2 and 3 return the current transmit and receive fill levels.
- R11: Reads of address 8 and of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| tx_level | input | LW | Transmit FIFO fill level, 0..DEPTH |
| rx_level | input | LW | Receive FIFO fill level, 0..DEPTH |
| tx_push | input | 1 | Push attempt into transmit FIFO |
| rx_push | input | 1 | Push attempt into receive FIFO |
| rx_pop | input | 1 | Pop attempt from receive FIFO |
| eng_busy | input | 1 | Serial engine busy |
| irq | output | 1 | Combined masked interrupt |

## Verification
The embedded assertions check, on every cycle, that:
- thresholds never hold a value of DEPTH or more;
- a rejected threshold write leaves the register unchanged;
- an error strobe always leaves its sticky bit set in the next cycle;
- a sticky bit with no clear selected keeps its value;
- a clear-all with no coincident event empties the sticky bits;
- `irq` stays low while the mask is zero.

The bench scenarios cover the rest: the exact bit layout of each view, the threshold comparison at the boundary levels, the depth-discovery probe, the mapping of each clear bit, the clear-versus-event race, and the mask-dependent interrupt.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int NUM_EV  = 5;
  localparam int NUM_STK = 3;

  // raw / mask / masked layout
  localparam int EV_TX_LOW  = 0;
  localparam int EV_TX_OVF  = 1;
  localparam int EV_RX_UNF  = 2;
  localparam int EV_RX_OVF  = 3;
  localparam int EV_RX_HIGH = 4;

  // status layout
  localparam int ST_BUSY    = 0;
  localparam int ST_TX_FULL = 1;
  localparam int ST_TX_EMPT = 2;
  localparam int ST_RX_EMPT = 3;
  localparam int ST_RX_FULL = 4;

  // clear register layout
  localparam int CL_ALL    = 0;
  localparam int CL_RX_UNF = 1;
  localparam int CL_RX_OVF = 2;
  localparam int CL_TX_OVF = 3;

  // sticky slot order
  localparam int SK_TX_OVF = 0;
  localparam int SK_RX_UNF = 1;
  localparam int SK_RX_OVF = 2;

  typedef enum logic [3:0] {
    A_TX_THR = 4'h0,
    A_RX_THR = 4'h1,
    A_TX_LVL = 4'h2,
    A_RX_LVL = 4'h3,
    A_STATUS = 4'h4,
    A_MASK   = 4'h5,
    A_RAW    = 4'h6,
    A_MASKED = 4'h7,
    A_CLEAR  = 4'h8
  } fic_addr_e;
endpackage

// File: rtl/fic_cfg_regs.sv
module fic_cfg_regs
  import fic_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [LW-1:0]     tx_thr,
  output logic [LW-1:0]     rx_thr,
  output logic [NUM_EV-1:0] mask
);
  localparam int NTHR = 2;

  logic [LW-1:0] thr_q [NTHR];
  logic          in_range;

  assign in_range = int'(wdata) < DEPTH;

  for (genvar gi = 0; gi < NTHR; gi++) begin : g_thr
    localparam logic [3:0] MY_ADDR = (gi == 0) ? A_TX_THR : A_RX_THR;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q[gi] <= '0;
      else if (wr && addr == MY_ADDR && in_range) thr_q[gi] <= wdata[LW-1:0];
    end

    AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr_q[gi]) < DEPTH); // R2
    AST_THR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == MY_ADDR && int'(wdata) >= DEPTH) |=> $stable(thr_q[gi])); // R2
  end

  assign tx_thr = thr_q[0];
  assign rx_thr = thr_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else if (wr && addr == A_MASK) mask <= wdata[NUM_EV-1:0];
  end
endmodule

// File: rtl/fic_flags.sv
module fic_flags
  import fic_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0]     tx_level,
  input  logic [LW-1:0]     rx_level,
  input  logic [LW-1:0]     tx_thr,
  input  logic [LW-1:0]     rx_thr,
  input  logic              eng_busy,
  output logic [NUM_EV-1:0] status,
  output logic              tx_low,
  output logic              rx_high,
  output logic              tx_full,
  output logic              rx_full,
  output logic              rx_empty
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  always_comb begin
    tx_full  = tx_level == FULL_LVL;
    rx_full  = rx_level == FULL_LVL;
    rx_empty = rx_level == '0;
    tx_low   = tx_level <= tx_thr;
    rx_high  = rx_level > rx_thr;
    status             = '0;
    status[ST_BUSY]    = eng_busy;
    status[ST_TX_FULL] = tx_full;
    status[ST_TX_EMPT] = tx_level == '0;
    status[ST_RX_EMPT] = rx_empty;
    status[ST_RX_FULL] = rx_full;
  end
endmodule

// File: rtl/fic_sticky.sv
module fic_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[gi] <= 1'b0;
      else        q[gi] <= set[gi] | (q[gi] & ~clr[gi]);
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[gi] |=> q[gi]); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q[gi] && !clr[gi]) |=> q[gi]); // R6
  end
endmodule

// File: rtl/fic_top.sv
module fic_top
  import fic_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_push,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          eng_busy,
  output logic          irq
);
  logic [LW-1:0]      tx_thr, rx_thr;
  logic [NUM_EV-1:0]  mask, status, raw, masked;
  logic               tx_low, rx_high, tx_full, rx_full, rx_empty;
  logic [NUM_STK-1:0] ev_set, ev_clr, sticky;
  logic               clr_wr;

  fic_cfg_regs #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mask(mask)
  );

  fic_flags #(.DEPTH(DEPTH), .LW(LW)) u_flags (
    .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .eng_busy(eng_busy), .status(status), .tx_low(tx_low), .rx_high(rx_high),
    .tx_full(tx_full), .rx_full(rx_full), .rx_empty(rx_empty)
  );

  assign clr_wr = reg_wr && reg_addr == A_CLEAR;

  always_comb begin
    ev_set[SK_TX_OVF] = tx_push && tx_full;
    ev_set[SK_RX_UNF] = rx_pop  && rx_empty;
    ev_set[SK_RX_OVF] = rx_push && rx_full;
    ev_clr[SK_TX_OVF] = clr_wr && (reg_wdata[CL_ALL] || reg_wdata[CL_TX_OVF]);
    ev_clr[SK_RX_UNF] = clr_wr && (reg_wdata[CL_ALL] || reg_wdata[CL_RX_UNF]);
    ev_clr[SK_RX_OVF] = clr_wr && (reg_wdata[CL_ALL] || reg_wdata[CL_RX_OVF]);
  end

  fic_sticky #(.N(NUM_STK)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr), .q(sticky)
  );

  always_comb begin
    raw             = '0;
    raw[EV_TX_LOW]  = tx_low;
    raw[EV_TX_OVF]  = sticky[SK_TX_OVF];
    raw[EV_RX_UNF]  = sticky[SK_RX_UNF];
    raw[EV_RX_OVF]  = sticky[SK_RX_OVF];
    raw[EV_RX_HIGH] = rx_high;
    masked          = raw & mask;
    irq             = |masked;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TX_THR: reg_rdata = DW'(tx_thr);
      A_RX_THR: reg_rdata = DW'(rx_thr);
      A_TX_LVL: reg_rdata = DW'(tx_level);
      A_RX_LVL: reg_rdata = DW'(rx_level);
      A_STATUS: reg_rdata = DW'(status);
      A_MASK:   reg_rdata = DW'(mask);
      A_RAW:    reg_rdata = DW'(raw);
      A_MASKED: reg_rdata = DW'(masked);
      default:  reg_rdata = '0;
    endcase
  end

  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R9
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && reg_wdata[CL_ALL] && ev_set == '0) |=> (raw[3:1] == 3'b000)); // R7
endmodule

// File: tb/tb_fic_top.sv
`timescale 1ns/1ps
module tb_fic_top;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [LW-1:0] tx_level = '0;
  logic [LW-1:0] rx_level = '0;
  logic          tx_push = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, eng_busy = 1'b0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit        is_irq;
    logic [7:0] exp;
    string     tag;
  } item_t;
  item_t sb_q[$];
  event  chk_ev;

  always #5 clk = ~clk;

  fic_top #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
    .rx_level(rx_level), .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
    .eng_busy(eng_busy), .irq(irq)
  );

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it  = sb_q.pop_front();
        got = it.is_irq ? {7'b0, irq} : reg_rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #2;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tx_push = 1'b1;
      1: rx_pop  = 1'b1;
      default: rx_push = 1'b1;
    endcase
    @(negedge clk);
    tx_push = 1'b0; rx_pop = 1'b0; rx_push = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    exp_rd(4'h0, 8'h00, "R1 tx threshold");
    exp_rd(4'h1, 8'h00, "R1 rx threshold");
    exp_rd(4'h5, 8'h00, "R1 mask");
    exp_rd(4'h6, 8'h01, "R1 raw");
    exp_irq(1'b0, "R1 irq");
    exp_rd(4'h4, 8'h0C, "R3 status idle");

    // R2 depth probe
    wr(4'h0, 8'd15); exp_rd(4'h0, 8'd15, "R2 tx accept depth-1");
    wr(4'h0, 8'd16); exp_rd(4'h0, 8'd15, "R2 tx reject depth");
    wr(4'h1, 8'd7);  exp_rd(4'h1, 8'd7,  "R2 rx accept");
    wr(4'h1, 8'd200); exp_rd(4'h1, 8'd7, "R2 rx reject large");
    wr(4'h0, 8'd7);

    // R4 / R5 thresholds at the boundary
    tx_level = 5'd7;  exp_rd(4'h6, 8'h01, "R4 tx at threshold");
    tx_level = 5'd8;  exp_rd(4'h6, 8'h00, "R4 tx above threshold");
    rx_level = 5'd7;  exp_rd(4'h6, 8'h00, "R5 rx at threshold");
    rx_level = 5'd8;  exp_rd(4'h6, 8'h10, "R5 rx above threshold");

    // R3 / R10 full levels and busy
    tx_level = 5'd16; rx_level = 5'd16; eng_busy = 1'b1;
    exp_rd(4'h4, 8'h13, "R3 status full busy");
    exp_rd(4'h2, 8'd16, "R10 tx level");
    exp_rd(4'h3, 8'd16, "R10 rx level");
    tx_level = 5'd8; rx_level = 5'd0; eng_busy = 1'b0;

    // R6 events
    pulse(0); exp_rd(4'h6, 8'h00, "R6 non-full push no event");
    tx_level = 5'd16; pulse(0); tx_level = 5'd8;
    exp_rd(4'h6, 8'h02, "R6 tx overflow");
    pulse(1); exp_rd(4'h6, 8'h06, "R6 rx underflow");
    rx_level = 5'd16; pulse(2); rx_level = 5'd0;
    exp_rd(4'h6, 8'h0E, "R6 rx overflow");
    repeat (3) @(negedge clk);
    exp_rd(4'h6, 8'h0E, "R6 sticky hold");

    // R7 selective clears
    wr(4'h8, 8'h02); exp_rd(4'h6, 8'h0A, "R7 clear underflow");
    wr(4'h8, 8'h08); exp_rd(4'h6, 8'h08, "R7 clear tx overflow");
    wr(4'h8, 8'h04); exp_rd(4'h6, 8'h00, "R7 clear rx overflow");
    tx_level = 5'd16; pulse(0); tx_level = 5'd8;
    pulse(1);
    wr(4'h8, 8'h01); exp_rd(4'h6, 8'h00, "R7 clear all");

    // R8 event and clear in the same cycle
    @(negedge clk);
    tx_level = 5'd16; tx_push = 1'b1;
    reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 8'h01;
    @(negedge clk);
    tx_push = 1'b0; reg_wr = 1'b0; tx_level = 5'd8;
    exp_rd(4'h6, 8'h02, "R8 event beats clear");

    // R9 mask
    wr(4'h5, 8'h02);
    exp_rd(4'h7, 8'h02, "R9 masked overflow");
    exp_irq(1'b1, "R9 irq on overflow");
    wr(4'h5, 8'h01);
    exp_rd(4'h7, 8'h00, "R9 masked off");
    exp_irq(1'b0, "R9 irq masked");
    tx_level = 5'd3;
    exp_rd(4'h7, 8'h01, "R9 masked tx low");
    exp_irq(1'b1, "R9 irq tx low");

    // R11 unmapped reads
    exp_rd(4'h8, 8'h00, "R11 clear reads zero");
    exp_rd(4'hF, 8'h00, "R11 unmapped");

    #5;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule